// File: doc/BRIEF.md
# Three-Channel Timer Register Front End

This block sits between an 8-bit processor bus and three down-counting timer channels. Using a 2-bit address, a write strobe and a read strobe, software programs each channel's operating mode, number format and byte access order through a shared control address. It then writes initial counts and reads back current counts through one data address per channel. The block assembles the bytes of each count. It hands each channel a one-cycle load strobe with the full 16-bit value, plus its mode and number-format settings. For a channel in mode 0, it also raises a hold signal while a two-byte count is only half written.

The counting itself happens elsewhere. Each channel's live count comes back into this block, which turns it into bus bytes in the programmed access order. A latch command, issued through the control address, freezes a snapshot of one channel's count for readback while the channel keeps counting. The snapshot stays in place until every byte of it has been read. After that, reads return the live count again.

Top module: `tmr_regif`

## Requirements
- R1: After reset, `rdata`, `load_stb`, `hold_o`, `cfg_stb`, `mode_o` and `bcd_o` are all zero. Every channel starts in low-byte-then-high-byte access order, so two data writes to a channel that has never been programmed load {second byte, first byte}.
- R2: A write to address 3 is a control word. Bits 7:6 name the channel, bits 5:4 the access code, bits 3:1 the mode and bit 0 number format (1 = decimal digits, 0 = binary). With a nonzero access code, the cycle after the write shows the named channel's new mode on `mode_o`, its format on `bcd_o` and a one-cycle `cfg_stb` pulse. A control word that names channel 3 changes nothing.
- R3: In access code 1 (low byte only), a data write loads {8'h00, byte}, with the `load_stb` pulse and value due the cycle after the write.
- R4: In access code 2 (high byte only), a data write loads {byte, 8'h00}, with the `load_stb` pulse and value due the cycle after the write.
- R5: In access code 3, the first data write loads nothing. The second loads {second byte, first byte}, with `load_stb` due the cycle after the second write.
- R6: When a channel is in mode 0 and access code 3, `hold_o` for that channel is high from the cycle after the first byte until the cycle after the second byte. In any other mode it stays low.
- R7: A control word with a nonzero access code resets that channel's write and read byte order, so the next data write or read is the low byte.
- R8: Reads return bytes of the live count the cycle after the read strobe. Code 1 returns bits 7:0, code 2 returns bits 15:8, and code 3 alternates between 7:0 and 15:8, starting with the low byte.
- R9: A control word with access code 0 is a latch command. It captures the named channel's count at that clock edge and restarts its read order at the low byte. Reads then return the captured value until all programmed bytes have been read (one for codes 1 and 2, two for code 3), after which reads return the live count.
- R10: A latch command sent to a channel that already holds an unread snapshot leaves that snapshot unchanged.
- R11: A read from address 3 returns 0 and does not advance any channel's read order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 2 | Bus address: 0 to 2 are channel data, 3 is the control word |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe, one cycle per byte |
| rd_en | input | 1 | Read strobe, one cycle per byte |
| rdata | output | 8 | Read data, registered, held between reads |
| cnt_in | input | 48 | Live count of each channel, channel i at bits 16i+15:16i |
| load_stb | output | 3 | One-cycle load strobe per channel |
| load_val | output | 48 | Assembled count per channel, channel i at bits 16i+15:16i |
| hold_o | output | 3 | Count hold per channel during a half-written mode 0 count |
| cfg_stb | output | 3 | One-cycle pulse per channel after its control word |
| mode_o | output | 9 | Mode per channel, channel i at bits 3i+2:3i |
| bcd_o | output | 3 | Number-format select per channel |

## Verification
Every result is exactly one register stage behind the bus strobe that causes it. The load strobe, load value, hold, mode, format and configuration pulse all appear in the cycle after the write edge. Read data appears in the cycle after the read edge. A latch captures the count presented at the edge of its control write. The bench drives each strobe for one cycle starting at a falling edge and samples at the next falling edge, which falls inside that one-cycle result window. It changes the live counts only between bus operations, so any change to a captured snapshot is visible.

// File: rtl/tmr_regif_pkg.sv
// Package: shared types and fixed byte geometry of the timer register front end.
// Assumes an 8-bit bus and 16-bit channel counts; the control word layout is fixed.
package tmr_regif_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = 2 * BYTE_W;
    localparam int MODE_W = 3;

    // byte access code carried in the control word
    typedef enum logic [1:0] {
        RW_LATCH = 2'd0,
        RW_LSB   = 2'd1,
        RW_MSB   = 2'd2,
        RW_BOTH  = 2'd3
    } rw_e;

    // control word, most significant field first
    typedef struct packed {
        logic [1:0]        sel;
        rw_e               rw;
        logic [MODE_W-1:0] mode;
        logic              bcd;
    } ctl_word_t;

endpackage

// File: rtl/tmr_ctrl_dec.sv
// Module: bus decoder. Turns one bus access into per-channel events:
// configuration write, latch command, data write and data read.
// Assumes at most one strobe event per cycle per address; purely combinational.
module tmr_ctrl_dec
    import tmr_regif_pkg::*;
#(
    parameter int N_CHAN = 3,
    parameter int AW     = 2
) (
    input  logic [AW-1:0]     addr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              wr_en,
    input  logic              rd_en,
    output ctl_word_t         cw,
    output logic [N_CHAN-1:0] cfg_we,
    output logic [N_CHAN-1:0] latch_cmd,
    output logic [N_CHAN-1:0] data_we,
    output logic [N_CHAN-1:0] data_re
);

    localparam logic [AW-1:0] CTL_ADDR = AW'(N_CHAN);

    logic ctl_wr;

    // control word view of the write data
    always_comb begin
        cw     = ctl_word_t'(wdata);
        ctl_wr = wr_en && (addr == CTL_ADDR);
    end

    // per-channel event decode
    always_comb begin
        cfg_we    = '0;
        latch_cmd = '0;
        data_we   = '0;
        data_re   = '0;
        for (int i = 0; i < N_CHAN; i++) begin
            if (ctl_wr && (cw.sel == 2'(i))) begin
                if (cw.rw == RW_LATCH) latch_cmd[i] = 1'b1;
                else                   cfg_we[i]    = 1'b1;
            end
            if (wr_en && (addr == AW'(i))) data_we[i] = 1'b1;
            if (rd_en && (addr == AW'(i))) data_re[i] = 1'b1;
        end
    end

endmodule

// File: rtl/tmr_chan_port.sv
// Module: register port of one timer channel. Holds mode, format and access
// code, assembles written bytes into a count load, sequences readback bytes
// and keeps a latched snapshot of the live count.
// Assumes cfg_we and data_we are never high together (different addresses).
module tmr_chan_port
    import tmr_regif_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  ctl_word_t         cw,
    input  logic              cfg_we,
    input  logic              latch_cmd,
    input  logic              data_we,
    input  logic              data_re,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [CNT_W-1:0]  cnt_in,
    output logic              load_stb,
    output logic [CNT_W-1:0]  load_val,
    output logic              hold,
    output logic              cfg_stb,
    output logic [MODE_W-1:0] mode,
    output logic              bcd,
    output rw_e               rw,
    output logic [BYTE_W-1:0] rd_byte
);

    rw_e               rw_q;
    logic [MODE_W-1:0] mode_q;
    logic              bcd_q;
    logic              cfg_stb_q;
    logic              wph_q;
    logic [BYTE_W-1:0] lsb_buf_q;
    logic              load_stb_q;
    logic [CNT_W-1:0]  load_val_q;
    logic              hold_q;
    logic              rph_q;
    logic              lat_q;
    logic [CNT_W-1:0]  lat_val_q;
    logic [CNT_W-1:0]  rd_src;
    logic              rd_hi;

    // configuration registers, written by a non-latch control word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rw_q      <= RW_BOTH;
            mode_q    <= '0;
            bcd_q     <= 1'b0;
            cfg_stb_q <= 1'b0;
        end else begin
            cfg_stb_q <= cfg_we;
            if (cfg_we) begin
                rw_q   <= cw.rw;
                mode_q <= cw.mode;
                bcd_q  <= cw.bcd;
            end
        end
    end

    // write byte sequencing and count load generation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wph_q      <= 1'b0;
            lsb_buf_q  <= '0;
            load_stb_q <= 1'b0;
            load_val_q <= '0;
            hold_q     <= 1'b0;
        end else begin
            load_stb_q <= 1'b0;
            if (cfg_we) begin
                wph_q  <= 1'b0;
                hold_q <= 1'b0;
            end else if (data_we) begin
                case (rw_q)
                    RW_LSB: begin
                        load_val_q <= {{BYTE_W{1'b0}}, wdata};
                        load_stb_q <= 1'b1;
                    end
                    RW_MSB: begin
                        load_val_q <= {wdata, {BYTE_W{1'b0}}};
                        load_stb_q <= 1'b1;
                    end
                    RW_BOTH: begin
                        if (!wph_q) begin
                            lsb_buf_q <= wdata;
                            wph_q     <= 1'b1;
                            hold_q    <= (mode_q == '0);
                        end else begin
                            load_val_q <= {wdata, lsb_buf_q};
                            load_stb_q <= 1'b1;
                            wph_q      <= 1'b0;
                            hold_q     <= 1'b0;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // readback source and byte select
    always_comb begin
        rd_src  = lat_q ? lat_val_q : cnt_in;
        rd_hi   = (rw_q == RW_MSB) || ((rw_q == RW_BOTH) && rph_q);
        rd_byte = rd_hi ? rd_src[CNT_W-1:BYTE_W] : rd_src[BYTE_W-1:0];
    end

    // read byte order and latch snapshot control
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rph_q     <= 1'b0;
            lat_q     <= 1'b0;
            lat_val_q <= '0;
        end else if (cfg_we) begin
            rph_q <= 1'b0;
            lat_q <= 1'b0;
        end else if (latch_cmd && !lat_q) begin
            lat_q     <= 1'b1;
            lat_val_q <= cnt_in;
            rph_q     <= 1'b0;
        end else if (data_re) begin
            if (rw_q == RW_BOTH) begin
                rph_q <= !rph_q;
                if (rph_q) lat_q <= 1'b0;
            end else begin
                lat_q <= 1'b0;
            end
        end
    end

    assign load_stb = load_stb_q;
    assign load_val = load_val_q;
    assign hold     = hold_q;
    assign cfg_stb  = cfg_stb_q;
    assign mode     = mode_q;
    assign bcd      = bcd_q;
    assign rw       = rw_q;

endmodule

// File: rtl/tmr_rd_mux.sv
// Module: registered read data selector. Picks the addressed channel's
// readback byte on a read strobe; the control address reads as zero.
// Assumes rd_byte of channel i sits at bits BYTE_W*i+BYTE_W-1:BYTE_W*i.
module tmr_rd_mux
    import tmr_regif_pkg::*;
#(
    parameter int N_CHAN = 3,
    parameter int AW     = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     rd_en,
    input  logic [AW-1:0]            addr,
    input  logic [N_CHAN*BYTE_W-1:0] rd_bytes,
    output logic [BYTE_W-1:0]        rdata
);

    logic [BYTE_W-1:0] sel_byte;

    // address to byte selection
    always_comb begin
        sel_byte = '0;
        for (int i = 0; i < N_CHAN; i++) begin
            if (addr == AW'(i)) sel_byte = rd_bytes[i*BYTE_W +: BYTE_W];
        end
    end

    // read data register, held between reads
    always_ff @(posedge clk) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= sel_byte;
    end

endmodule

// File: rtl/tmr_regif.sv
// Module: top of the timer register front end. Decodes bus accesses and
// instantiates one register port per channel plus the read data selector.
// Assumes N_CHAN <= 3 so the control word's 2-bit channel field covers all.
module tmr_regif
    import tmr_regif_pkg::*;
#(
    parameter int N_CHAN = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [1:0]               addr,
    input  logic [7:0]               wdata,
    input  logic                     wr_en,
    input  logic                     rd_en,
    output logic [7:0]               rdata,
    input  logic [N_CHAN*16-1:0]     cnt_in,
    output logic [N_CHAN-1:0]        load_stb,
    output logic [N_CHAN*16-1:0]     load_val,
    output logic [N_CHAN-1:0]        hold_o,
    output logic [N_CHAN-1:0]        cfg_stb,
    output logic [N_CHAN*3-1:0]      mode_o,
    output logic [N_CHAN-1:0]        bcd_o
);

    localparam int AW = $clog2(N_CHAN + 1);

    ctl_word_t                cw;
    logic [N_CHAN-1:0]        cfg_we;
    logic [N_CHAN-1:0]        latch_cmd;
    logic [N_CHAN-1:0]        data_we;
    logic [N_CHAN-1:0]        data_re;
    logic [N_CHAN*BYTE_W-1:0] rd_bytes;
    logic [N_CHAN*2-1:0]      ch_rw;

    tmr_ctrl_dec #(.N_CHAN(N_CHAN), .AW(AW)) u_dec (
        .addr      (addr[AW-1:0]),
        .wdata     (wdata),
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .cw        (cw),
        .cfg_we    (cfg_we),
        .latch_cmd (latch_cmd),
        .data_we   (data_we),
        .data_re   (data_re)
    );

    for (genvar g = 0; g < N_CHAN; g++) begin : g_chan
        rw_e rw_g;
        tmr_chan_port u_port (
            .clk       (clk),
            .rst_n     (rst_n),
            .cw        (cw),
            .cfg_we    (cfg_we[g]),
            .latch_cmd (latch_cmd[g]),
            .data_we   (data_we[g]),
            .data_re   (data_re[g]),
            .wdata     (wdata),
            .cnt_in    (cnt_in[g*CNT_W +: CNT_W]),
            .load_stb  (load_stb[g]),
            .load_val  (load_val[g*CNT_W +: CNT_W]),
            .hold      (hold_o[g]),
            .cfg_stb   (cfg_stb[g]),
            .mode      (mode_o[g*MODE_W +: MODE_W]),
            .bcd       (bcd_o[g]),
            .rw        (rw_g),
            .rd_byte   (rd_bytes[g*BYTE_W +: BYTE_W])
        );
        assign ch_rw[g*2 +: 2] = rw_g;
    end

    tmr_rd_mux #(.N_CHAN(N_CHAN), .AW(AW)) u_rdmux (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en    (rd_en),
        .addr     (addr[AW-1:0]),
        .rd_bytes (rd_bytes),
        .rdata    (rdata)
    );

endmodule

// File: rtl/tmr_regif_chk.sv
// Module: property checker for the timer register front end, bound to the top.
// Assumes the port layout of tmr_regif; observes ports and the per-channel access code.
module tmr_regif_chk #(
    parameter int N_CHAN = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [1:0]           addr,
    input logic [7:0]           wdata,
    input logic                 wr_en,
    input logic                 rd_en,
    input logic [7:0]           rdata,
    input logic [N_CHAN-1:0]    load_stb,
    input logic [N_CHAN*16-1:0] load_val,
    input logic [N_CHAN-1:0]    hold_o,
    input logic [N_CHAN-1:0]    cfg_stb,
    input logic [N_CHAN*3-1:0]  mode_o,
    input logic [N_CHAN*2-1:0]  ch_rw
);

    localparam logic [1:0] CTL_ADDR = 2'(N_CHAN);

    AST_LOAD_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(load_stb)); // R5

    AST_CTL_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == CTL_ADDR) |=> (rdata == 8'h00)); // R11

    for (genvar i = 0; i < N_CHAN; i++) begin : g_chk
        AST_CFG_APPLY: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && addr == CTL_ADDR && wdata[7:6] == 2'(i) && wdata[5:4] != 2'd0)
            |=> (cfg_stb[i] && mode_o[i*3 +: 3] == $past(wdata[3:1]))); // R2

        AST_LSB_ONLY_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && addr == 2'(i) && ch_rw[i*2 +: 2] == 2'd1)
            |=> (load_stb[i] && load_val[i*16+8 +: 8] == 8'h00)); // R3

        AST_MSB_ONLY_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && addr == 2'(i) && ch_rw[i*2 +: 2] == 2'd2)
            |=> (load_stb[i] && load_val[i*16 +: 8] == 8'h00)); // R4

        AST_HOLD_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(hold_o[i]) |-> (load_stb[i] || cfg_stb[i])); // R6
    end

endmodule

bind tmr_regif tmr_regif_chk #(.N_CHAN(N_CHAN)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (addr),
    .wdata    (wdata),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .rdata    (rdata),
    .load_stb (load_stb),
    .load_val (load_val),
    .hold_o   (hold_o),
    .cfg_stb  (cfg_stb),
    .mode_o   (mode_o),
    .ch_rw    (ch_rw)
);

// File: tb/tmr_regif_tb.sv
// Directed bench for tmr_regif: one task per scenario, each checking its own results.
module tmr_regif_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  rdata;
    logic [47:0] cnt_in = '0;
    logic [2:0]  load_stb;
    logic [47:0] load_val;
    logic [2:0]  hold_o;
    logic [2:0]  cfg_stb;
    logic [8:0]  mode_o;
    logic [2:0]  bcd_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    tmr_regif u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (addr),
        .wdata    (wdata),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .rdata    (rdata),
        .cnt_in   (cnt_in),
        .load_stb (load_stb),
        .load_val (load_val),
        .hold_o   (hold_o),
        .cfg_stb  (cfg_stb),
        .mode_o   (mode_o),
        .bcd_o    (bcd_o)
    );

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // one-cycle write; returns at the falling edge where results are visible
    task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        v = rdata;
    endtask

    function automatic logic [7:0] ctl(input int ch, input int rw, input int md, input int b);
        return {2'(ch), 2'(rw), 3'(md), 1'(b)};
    endfunction

    task automatic t_reset();
        check("R1 rdata", rdata, 0);
        check("R1 load_stb", load_stb, 0);
        check("R1 hold", hold_o, 0);
        check("R1 cfg_stb", cfg_stb, 0);
        check("R1 mode", mode_o, 0);
        check("R1 bcd", bcd_o, 0);
        bus_wr(2'd0, 8'h34);
        check("R1 no load after first byte", load_stb, 0);
        bus_wr(2'd0, 8'h12);
        check("R1 default order load_stb", load_stb, 3'b001);
        check("R1 default order value", load_val[15:0], 16'h1234);
    endtask

    task automatic t_ctl();
        bus_wr(2'd3, ctl(1, 1, 4, 1));
        check("R2 cfg_stb", cfg_stb, 3'b010);
        check("R2 mode ch1", mode_o[5:3], 4);
        check("R2 bcd", bcd_o, 3'b010);
        bus_wr(2'd3, ctl(3, 3, 5, 1));
        check("R2 sel3 cfg_stb", cfg_stb, 0);
        check("R2 sel3 mode", mode_o, 9'(4 << 3));
        check("R2 sel3 bcd", bcd_o, 3'b010);
    endtask

    task automatic t_single_byte();
        bus_wr(2'd1, 8'hA5);
        check("R3 load_stb", load_stb, 3'b010);
        check("R3 value", load_val[31:16], 16'h00A5);
        bus_wr(2'd3, ctl(2, 2, 2, 0));
        bus_wr(2'd2, 8'h5C);
        check("R4 load_stb", load_stb, 3'b100);
        check("R4 value", load_val[47:32], 16'h5C00);
    endtask

    task automatic t_two_byte();
        bus_wr(2'd3, ctl(0, 3, 0, 0));
        bus_wr(2'd0, 8'h78);
        check("R5 no strobe on first", load_stb, 0);
        check("R6 hold after first byte", hold_o, 3'b001);
        bus_wr(2'd0, 8'h56);
        check("R5 strobe on second", load_stb, 3'b001);
        check("R5 value", load_val[15:0], 16'h5678);
        check("R6 hold released", hold_o, 0);
        bus_wr(2'd3, ctl(0, 3, 2, 0));
        bus_wr(2'd0, 8'h99);
        check("R6 no hold in mode 2", hold_o, 0);
        bus_wr(2'd3, ctl(0, 3, 2, 0));
        bus_wr(2'd0, 8'h11);
        check("R7 restart expects low byte", load_stb, 0);
        bus_wr(2'd0, 8'h22);
        check("R7 value after restart", load_val[15:0], 16'h2211);
    endtask

    task automatic t_read();
        logic [7:0] v;
        cnt_in = {16'h2468, 16'h1357, 16'hBEEF};
        bus_rd(2'd0, v); check("R8 both first low", v, 8'hEF);
        bus_rd(2'd0, v); check("R8 both then high", v, 8'hBE);
        bus_rd(2'd1, v); check("R8 low only", v, 8'h57);
        bus_rd(2'd2, v); check("R8 high only", v, 8'h24);
        bus_rd(2'd0, v);
        bus_wr(2'd3, ctl(0, 3, 2, 0));
        bus_rd(2'd0, v); check("R7 read order reset", v, 8'hEF);
    endtask

    task automatic t_latch();
        logic [7:0] v;
        cnt_in[15:0] = 16'h1234;
        bus_wr(2'd3, ctl(0, 0, 0, 0));
        cnt_in[15:0] = 16'h0FFF;
        bus_wr(2'd3, ctl(0, 0, 0, 0));
        cnt_in[15:0] = 16'h0AAA;
        bus_rd(2'd0, v); check("R9 R10 latched low", v, 8'h34);
        bus_rd(2'd0, v); check("R9 R10 latched high", v, 8'h12);
        bus_rd(2'd0, v); check("R9 live after release", v, 8'hAA);
        cnt_in[31:16] = 16'h00C3;
        bus_wr(2'd3, ctl(1, 0, 0, 0));
        cnt_in[31:16] = 16'h0011;
        bus_rd(2'd1, v); check("R9 single byte latched", v, 8'hC3);
        bus_rd(2'd1, v); check("R9 single byte released", v, 8'h11);
    endtask

    task automatic t_ctl_read();
        logic [7:0] v;
        bus_rd(2'd3, v); check("R11 control reads zero", v, 0);
        bus_rd(2'd0, v); check("R11 order not advanced", v, 8'h0A);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ctl();
        t_single_byte();
        t_two_byte();
        t_read();
        t_latch();
        t_ctl_read();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule